// File: doc/BRIEF.md
# Direct-Mapped Fetch Cache with Burst Refill

This block is a read-only, direct-mapped cache placed between a processor's instruction-fetch port and a slow memory that returns a block as a word-serial burst. Each incoming byte address is split into a byte offset, a word-in-block select, an index and a tag. The index picks exactly one entry. The access hits when that entry is valid and its stored tag matches the tag bits of the address. A hit returns the word in the same cycle.

On a miss the requester is stalled and the block address goes out on a one-cycle memory request. The words that come back in ascending order are written into the data store one by one. As soon as the word the processor asked for shows up, it is passed straight through and the stall ends (early restart), while the rest of the block keeps filling. The tag and valid bit are committed only with the last word, so a request made during the remainder of the fill waits until the block is complete and is then looked up normally. Two saturating counters record completed accesses and misses, and a synchronous clear input resets them.

Top module: `dm_fetch_cache`

## Requirements
- R1: With the default sizes (32-bit addresses, 256 blocks, 4 words of 32 bits), addr[1:0] is ignored, addr[3:2] picks the word, addr[11:4] is the index and addr[31:12] is the tag. An access hits only when the indexed entry is valid and its tag equals addr[31:12].
- R2: Reset clears every valid bit, so the first access to any address after reset is a miss. After reset, ready, mem_req and both counters are 0.
- R3: A hit raises ready in the same cycle that req is high, with rdata equal to the stored word.
- R4: A miss keeps ready low and raises mem_req for exactly one cycle, in the cycle after the miss, with mem_addr holding the block-aligned address. Each miss adds one to miss_cnt.
- R5: Refill words are accepted in ascending order, one per mem_valid strobe. With a memory that delivers the first word 50 cycles after the request and each later word 10 cycles after the previous one, a four-word fill completes so that a lookup is possible again 82 cycles after the miss cycle.
- R6: Early restart: ready rises with rdata equal to mem_rdata in the cycle the strobe carries the requested word. With the memory timing above, a miss on word k is served 51+10k cycles after the miss cycle.
- R7: A request made while a fill is still in progress keeps ready low until the fill completes. It is then looked up as a normal hit or miss.
- R8: A block with the same index but a different tag replaces the resident block. Alternating accesses to two such blocks miss every time.
- R9: Configured with 8 one-word blocks, the word-address trace 22, 26, 22, 26, 16, 3, 16, 18 gives 5 misses. Configured with 4 one-word blocks, the byte-address trace 88, 104, 88, 104, 64, 12, 64, 72 gives 7 misses.
- R10: acc_cnt counts cycles with req and ready both high. Both counters stop at their all-ones value. stat_clr forces both to 0 on the next edge and takes priority over an increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_clr | input | 1 | Synchronous clear of both counters |
| req | input | 1 | Fetch request, held until ready |
| addr | input | ADDR_W | Fetch byte address, held with req |
| ready | output | 1 | Word delivered this cycle |
| rdata | output | DATA_W | Fetched word |
| mem_req | output | 1 | One-cycle block request to memory |
| mem_addr | output | ADDR_W | Block-aligned request address |
| mem_valid | input | 1 | Strobe marking a refill word |
| mem_rdata | input | DATA_W | Refill word |
| acc_cnt | output | CNT_W | Saturating completed-access count |
| miss_cnt | output | CNT_W | Saturating miss count |

## Verification
The bench targets the point where the stall ends. It misses on the first, third and last word of a block and checks that the wait is exactly 51+10k cycles. A design that waited for the whole block, or released on the wrong strobe, would show the wrong latency or return a neighbouring word. It then issues a request right after each early restart. A design that committed the tag too early would report a hit before the data was stored, and one that dropped the pending request would hang.

Byte-offset aliasing and a tag differing only in its lowest bit probe the field split, since a mis-sliced index or tag shows up as a false hit or a false miss. The two classic traces and a ping-pong pattern run on small configurations and pin down the miss counts. Narrow counters check saturation and clearing.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    // Refill controller states
    typedef enum logic [1:0] {
        FS_LOOKUP = 2'd0,
        FS_ISSUE  = 2'd1,
        FS_FILL   = 2'd2
    } fill_state_e;

    // Saturating increment on a counter held in a 64-bit container
    function automatic logic [63:0] sat_step(input logic [63:0] cur, input logic [63:0] top);
        return (cur == top) ? cur : cur + 64'd1;
    endfunction

endpackage

// File: rtl/dmc_tag_array.sv
module dmc_tag_array #(
    parameter int DEPTH = 256,
    parameter int IDX_W = 8,
    parameter int TAG_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [DEPTH-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst)        valid_q <= '0;
        else if (wr_en) valid_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_idx] <= wr_tag;
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

    // Entries come out of reset empty
    assert_cold_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (valid_q == '0));

    // A committed entry is visible as valid from the next cycle
    assert_commit_valid_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> valid_q[$past(wr_idx)]);

endmodule

// File: rtl/dmc_data_array.sv
module dmc_data_array #(
    parameter int DEPTH  = 1024,
    parameter int AW     = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/dmc_refill_ctrl.sv
module dmc_refill_ctrl
    import dmc_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int TAG_W  = 20,
    parameter int WSEL_W = 2,
    parameter int WPB    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic [TAG_W-1:0]  start_tag,
    input  logic [WSEL_W-1:0] start_word,
    input  logic              mem_valid,
    input  logic              req,
    output fill_state_e       state,
    output logic [IDX_W-1:0]  fill_idx,
    output logic [TAG_W-1:0]  fill_tag,
    output logic [WSEL_W-1:0] fill_word,
    output logic              word_wr,
    output logic              commit,
    output logic              deliver,
    output logic              mem_req
);
    localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(WPB - 1);

    fill_state_e       state_q;
    logic [WSEL_W-1:0] cnt_q;
    logic [WSEL_W-1:0] want_q;
    logic              served_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= FS_LOOKUP;
            cnt_q    <= '0;
            want_q   <= '0;
            served_q <= 1'b0;
            fill_idx <= '0;
            fill_tag <= '0;
        end else begin
            unique case (state_q)
                FS_LOOKUP: if (start) begin
                    state_q  <= FS_ISSUE;
                    fill_idx <= start_idx;
                    fill_tag <= start_tag;
                    want_q   <= start_word;
                    cnt_q    <= '0;
                    served_q <= 1'b0;
                end
                FS_ISSUE: state_q <= FS_FILL;
                FS_FILL: if (mem_valid) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (deliver)            served_q <= 1'b1;
                    if (cnt_q == LAST_WORD) state_q  <= FS_LOOKUP;
                end
                default: state_q <= FS_LOOKUP;
            endcase
        end
    end

    assign state     = state_q;
    assign fill_word = cnt_q;
    assign mem_req   = (state_q == FS_ISSUE);
    assign word_wr   = (state_q == FS_FILL) && mem_valid;
    assign commit    = word_wr && (cnt_q == LAST_WORD);
    assign deliver   = word_wr && (cnt_q == want_q) && !served_q;

    assert_one_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    assert_restart_waiting_R6: assert property (@(posedge clk) disable iff (rst)
        deliver |-> req);

    assert_fill_done_R5: assert property (@(posedge clk) disable iff (rst)
        commit |=> (state == FS_LOOKUP));

endmodule

// File: rtl/dmc_stats.sv
module dmc_stats
    import dmc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             acc_inc,
    input  logic             miss_inc,
    output logic [CNT_W-1:0] acc_cnt,
    output logic [CNT_W-1:0] miss_cnt
);
    localparam logic [63:0] TOP = 64'({CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_cnt  <= '0;
            miss_cnt <= '0;
        end else begin
            if (acc_inc)  acc_cnt  <= CNT_W'(sat_step(64'(acc_cnt), TOP));
            if (miss_inc) miss_cnt <= CNT_W'(sat_step(64'(miss_cnt), TOP));
        end
    end

    assert_sat_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (miss_cnt == '1 && !clr) |=> (miss_cnt == '1));

    assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_cnt == '0 && miss_cnt == '0));

endmodule

// File: rtl/dm_fetch_cache.sv
module dm_fetch_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W          = 32,
    parameter int DATA_W          = 32,
    parameter int NUM_BLOCKS      = 256,
    parameter int WORDS_PER_BLOCK = 4,
    parameter int CNT_W           = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stat_clr,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  acc_cnt,
    output logic [CNT_W-1:0]  miss_cnt
);
    localparam int BOFF_W    = $clog2(DATA_W / 8);
    localparam int WSEL_BITS = $clog2(WORDS_PER_BLOCK);
    localparam int WSEL_W    = (WSEL_BITS > 0) ? WSEL_BITS : 1;
    localparam int IDX_W     = $clog2(NUM_BLOCKS);
    localparam int TAG_LSB   = BOFF_W + WSEL_BITS + IDX_W;
    localparam int TAG_W     = ADDR_W - TAG_LSB;
    localparam int DA_W      = IDX_W + WSEL_BITS;
    localparam int DEPTH_W   = NUM_BLOCKS * WORDS_PER_BLOCK;

    logic [IDX_W-1:0]  a_idx;
    logic [TAG_W-1:0]  a_tag;
    logic [WSEL_W-1:0] a_word;
    logic [DA_W-1:0]   rd_da, wr_da;
    logic              unused_boff;

    fill_state_e       state;
    logic [IDX_W-1:0]  fill_idx;
    logic [TAG_W-1:0]  fill_tag;
    logic [WSEL_W-1:0] fill_word;
    logic              word_wr, commit, deliver;
    logic              ent_valid;
    logic [TAG_W-1:0]  ent_tag;
    logic [DATA_W-1:0] ent_word;
    logic              in_lookup, tag_match, hit, miss_start;

    assign a_idx       = addr[BOFF_W + WSEL_BITS +: IDX_W];
    assign a_tag       = addr[ADDR_W-1:TAG_LSB];
    assign unused_boff = ^addr[BOFF_W-1:0];

    generate
        if (WSEL_BITS > 0) begin : g_multi_word
            assign a_word = addr[BOFF_W +: WSEL_W];
            assign rd_da  = {a_idx, a_word};
            assign wr_da  = {fill_idx, fill_word};
        end else begin : g_single_word
            logic unused_fw;
            assign a_word    = '0;
            assign rd_da     = a_idx;
            assign wr_da     = fill_idx;
            assign unused_fw = ^fill_word;
        end
    endgenerate

    dmc_tag_array #(.DEPTH(NUM_BLOCKS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst(rst),
        .rd_idx(a_idx), .rd_valid(ent_valid), .rd_tag(ent_tag),
        .wr_en(commit), .wr_idx(fill_idx), .wr_tag(fill_tag)
    );

    dmc_data_array #(.DEPTH(DEPTH_W), .AW(DA_W), .DATA_W(DATA_W)) u_data (
        .clk(clk),
        .rd_addr(rd_da), .rd_data(ent_word),
        .wr_en(word_wr), .wr_addr(wr_da), .wr_data(mem_rdata)
    );

    assign in_lookup  = (state == FS_LOOKUP);
    assign tag_match  = ent_valid && (ent_tag == a_tag);
    assign hit        = in_lookup && req && tag_match;
    assign miss_start = in_lookup && req && !tag_match;

    dmc_refill_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .WSEL_W(WSEL_W), .WPB(WORDS_PER_BLOCK)) u_ctrl (
        .clk(clk), .rst(rst),
        .start(miss_start), .start_idx(a_idx), .start_tag(a_tag), .start_word(a_word),
        .mem_valid(mem_valid), .req(req),
        .state(state), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_word(fill_word),
        .word_wr(word_wr), .commit(commit), .deliver(deliver), .mem_req(mem_req)
    );

    assign ready    = hit || (deliver && req);
    assign rdata    = deliver ? mem_rdata : ent_word;
    assign mem_addr = {fill_tag, fill_idx, {(ADDR_W - TAG_W - IDX_W){1'b0}}};

    dmc_stats #(.CNT_W(CNT_W)) u_stats (
        .clk(clk), .rst(rst), .clr(stat_clr),
        .acc_inc(req && ready), .miss_inc(miss_start),
        .acc_cnt(acc_cnt), .miss_cnt(miss_cnt)
    );

    // A lookup miss is followed by the block request on the next cycle
    assert_issue_R4: assert property (@(posedge clk) disable iff (rst)
        miss_start |=> mem_req);

    // No word leaves the cache while a fill owns the arrays, except the restart word
    assert_hold_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (!in_lookup && !deliver) |-> !ready);

endmodule

// File: tb/sim_dm_fetch_cache.sv
`timescale 1ns/1ps

module sim_burst_mem #(
    parameter int WPB   = 4,
    parameter int FIRST = 50,
    parameter int NEXT  = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mem_req,
    input  logic [31:0] mem_addr,
    output logic        mem_valid,
    output logic [31:0] mem_rdata
);
    logic        busy;
    logic [31:0] base;
    int          t;
    int          k;

    function automatic logic [31:0] mw(input logic [31:0] a);
        return ({a[31:2], 2'b00} * 32'd40503) ^ 32'h5A5A_C3C3;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            t    <= 0;
            base <= '0;
        end else if (mem_req) begin
            busy <= 1'b1;
            base <= mem_addr;
            t    <= 1;
        end else if (busy) begin
            t <= t + 1;
            if (t == FIRST + NEXT * (WPB - 1)) busy <= 1'b0;
        end
    end

    always_comb begin
        k         = (t >= FIRST) ? (t - FIRST) / NEXT : 0;
        mem_valid = busy && (t >= FIRST) && ((t - FIRST) % NEXT == 0) && (k < WPB);
        mem_rdata = mw(base + 32'(4 * k));
    end
endmodule

module sim_dm_fetch_cache;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        req [3];
    logic [31:0] addr [3];
    logic        clr [3];
    logic        ready [3];
    logic [31:0] rdata [3];
    logic        mreq [3];
    logic [31:0] maddr [3];
    logic        mval [3];
    logic [31:0] mdat [3];
    logic [31:0] acc0, miss0, acc2, miss2;
    logic [2:0]  acc1, miss1;

    dm_fetch_cache u0 (
        .clk(clk), .rst(rst), .stat_clr(clr[0]), .req(req[0]), .addr(addr[0]),
        .ready(ready[0]), .rdata(rdata[0]), .mem_req(mreq[0]), .mem_addr(maddr[0]),
        .mem_valid(mval[0]), .mem_rdata(mdat[0]), .acc_cnt(acc0), .miss_cnt(miss0));
    sim_burst_mem #(.WPB(4)) m0 (.clk(clk), .rst(rst), .mem_req(mreq[0]), .mem_addr(maddr[0]),
        .mem_valid(mval[0]), .mem_rdata(mdat[0]));

    dm_fetch_cache #(.NUM_BLOCKS(8), .WORDS_PER_BLOCK(1), .CNT_W(3)) u1 (
        .clk(clk), .rst(rst), .stat_clr(clr[1]), .req(req[1]), .addr(addr[1]),
        .ready(ready[1]), .rdata(rdata[1]), .mem_req(mreq[1]), .mem_addr(maddr[1]),
        .mem_valid(mval[1]), .mem_rdata(mdat[1]), .acc_cnt(acc1), .miss_cnt(miss1));
    sim_burst_mem #(.WPB(1)) m1 (.clk(clk), .rst(rst), .mem_req(mreq[1]), .mem_addr(maddr[1]),
        .mem_valid(mval[1]), .mem_rdata(mdat[1]));

    dm_fetch_cache #(.NUM_BLOCKS(4), .WORDS_PER_BLOCK(1)) u2 (
        .clk(clk), .rst(rst), .stat_clr(clr[2]), .req(req[2]), .addr(addr[2]),
        .ready(ready[2]), .rdata(rdata[2]), .mem_req(mreq[2]), .mem_addr(maddr[2]),
        .mem_valid(mval[2]), .mem_rdata(mdat[2]), .acc_cnt(acc2), .miss_cnt(miss2));
    sim_burst_mem #(.WPB(1)) m2 (.clk(clk), .rst(rst), .mem_req(mreq[2]), .mem_addr(maddr[2]),
        .mem_valid(mval[2]), .mem_rdata(mdat[2]));

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    typedef struct {
        int          u;
        logic [31:0] data;
        int          lat;
        string       rq;
    } exp_t;
    exp_t sbq[$];

    int nblk [3] = '{256, 8, 4};
    int wpb  [3] = '{4, 1, 1};
    bit mv   [3][256];
    int mt   [3][256];
    int stall_left [3];
    int exp_miss [3];
    int exp_acc  [3];
    int waitc [3];

    function automatic logic [31:0] mw(input logic [31:0] a);
        return ({a[31:2], 2'b00} * 32'd40503) ^ 32'h5A5A_C3C3;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Driver: compute expectation from the model, push it, then run the handshake
    task automatic access(input int u, input logic [31:0] a, input string rq);
        exp_t e;
        int blk, idx, tg, wd;
        blk = int'(a) / (4 * wpb[u]);
        idx = blk % nblk[u];
        tg  = blk / nblk[u];
        wd  = (int'(a) / 4) % wpb[u];
        e.u = u; e.data = mw(a); e.rq = rq;
        e.lat = stall_left[u];
        if (mv[u][idx] && mt[u][idx] == tg) begin
            stall_left[u] = 0;
        end else begin
            e.lat += 51 + 10 * wd;
            stall_left[u] = 10 * (wpb[u] - 1 - wd);
            mv[u][idx] = 1'b1;
            mt[u][idx] = tg;
            exp_miss[u]++;
        end
        exp_acc[u]++;
        sbq.push_back(e);
        req[u]  = 1'b1;
        addr[u] = a;
        do @(negedge clk); while (!ready[u]);
        @(posedge clk); #1;
        req[u] = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
        for (int u = 0; u < 3; u++) stall_left[u] = (stall_left[u] > n) ? stall_left[u] - n : 0;
    endtask

    task automatic pulse_clr(input int u);
        clr[u] = 1'b1;
        @(posedge clk); #1;
        clr[u] = 1'b0;
        for (int v = 0; v < 3; v++) stall_left[v] = (stall_left[v] > 1) ? stall_left[v] - 1 : 0;
    endtask

    // Monitor: pop and compare each delivered word
    always @(negedge clk) begin
        for (int u = 0; u < 3; u++) begin
            if (!rst && req[u]) begin
                if (ready[u]) begin
                    if (sbq.size() == 0) begin
                        chk(0, "R3", "unexpected delivery", 1, 0);
                    end else begin
                        exp_t e;
                        e = sbq.pop_front();
                        chk(e.u == u, e.rq, "unit", u, e.u);
                        chk(rdata[u] == e.data, e.rq, "rdata", rdata[u], e.data);
                        chk(waitc[u] == e.lat, e.rq, "stall cycles", waitc[u], e.lat);
                    end
                    waitc[u] = 0;
                end else begin
                    waitc[u]++;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int u = 0; u < 3; u++) begin
            req[u] = 1'b0; addr[u] = '0; clr[u] = 1'b0;
            stall_left[u] = 0; exp_miss[u] = 0; exp_acc[u] = 0; waitc[u] = 0;
            for (int i = 0; i < 256; i++) begin mv[u][i] = 1'b0; mt[u][i] = 0; end
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R2: reset state
        chk(ready[0] == 1'b0, "R2", "ready after reset", ready[0], 0);
        chk(mreq[0] == 1'b0, "R2", "mem_req after reset", mreq[0], 0);
        chk(acc0 == 0 && miss0 == 0, "R2", "counters after reset", acc0 + miss0, 0);
        @(posedge clk); #1;

        // Cold miss on word 0, then a same-block request that waits for the fill (R2, R6, R5, R7)
        access(0, 32'h100, "R2");
        access(0, 32'h104, "R5");
        // Miss on the last word of a block, then a hit on the same block (R6)
        access(0, 32'h20C, "R6");
        access(0, 32'h208, "R3");
        // Miss on word 2, then a miss elsewhere that first waits out the fill (R6, R7)
        access(0, 32'h308, "R6");
        access(0, 32'h400, "R7");
        idle(40);
        // Byte offset ignored, tag bit 12 distinguishes (R1)
        access(0, 32'h101, "R1");
        access(0, 32'h1100, "R1");
        // Evicted block misses again (R8)
        access(0, 32'h100, "R8");
        access(0, 32'h0FF0, "R1");
        idle(40);
        access(0, 32'h0FFC, "R3");
        access(0, 32'h0FF4, "R3");
        access(0, 32'h0FF4, "R3");
        @(negedge clk);
        chk(miss0 == 32'(exp_miss[0]), "R4", "miss count", miss0, exp_miss[0]);
        chk(acc0 == 32'(exp_acc[0]), "R10", "access count", acc0, exp_acc[0]);
        @(posedge clk); #1;
        pulse_clr(0);
        @(negedge clk);
        chk(acc0 == 0 && miss0 == 0, "R10", "counters after clear", acc0 + miss0, 0);
        @(posedge clk); #1;

        // Trace on 8 one-word blocks (R9), counters saturate at 7 (R10)
        begin
            int tr1 [8] = '{22, 26, 22, 26, 16, 3, 16, 18};
            foreach (tr1[i]) access(1, 32'(tr1[i] * 4), "R9");
        end
        @(negedge clk);
        chk(miss1 == 3'd5, "R9", "miss count 8x1", miss1, 5);
        chk(acc1 == 3'd7, "R10", "saturated access count", acc1, 7);
        @(posedge clk); #1;
        pulse_clr(1);
        @(negedge clk);
        chk(acc1 == 0 && miss1 == 0, "R10", "narrow counters cleared", acc1 + miss1, 0);
        @(posedge clk); #1;

        // Trace on 4 one-word blocks (R9)
        begin
            int tr2 [8] = '{88, 104, 88, 104, 64, 12, 64, 72};
            foreach (tr2[i]) access(2, 32'(tr2[i]), "R9");
        end
        @(negedge clk);
        chk(miss2 == 32'd7, "R9", "miss count 4x1", miss2, 7);
        @(posedge clk); #1;
        pulse_clr(2);
        // Ping-pong between word 0 and word 4 (R8)
        for (int i = 0; i < 4; i++) access(2, (i % 2 == 0) ? 32'd0 : 32'd16, "R8");
        @(negedge clk);
        chk(miss2 == 32'd4, "R8", "ping-pong misses", miss2, 4);
        chk(sbq.size() == 0, "R3", "scoreboard drained", sbq.size(), 0);
        finish_run();
    end
endmodule